// File: doc/BRIEF.md
# Paged Word Reader for Non-Executable Read-Only Storage

This block sits on a processor's byte-wide I/O bus and lets software pull 16-bit words out of a bank of read-only storage that the processor cannot execute from directly. It answers to one device number. A control byte sent to that device chooses the active storage region. Two byte writes then set a word pointer, high half first. Each later read request returns the word at the pointer and advances the pointer by one. Addresses count words, and the space covers 65536 of them.

Two control codes reach real storage: 0x08 selects the common/language bank and 0x04 selects the second language bank. Code 0x02 names an empty slot that reads as all zeros. Every other code, including 0x00, 0x82, 0x84 and 0x88, and the state after reset, reads as all ones. The storage is slower than the processor, so each read holds a ready flag low for a fixed number of cycles, and the word appears with a one-cycle valid pulse. A typical use is a self-test that loads pointer 0xC000 in the common bank and streams one 6 KiB segment through a checksum.

Top module: `ros_port_ctrl`

## Requirements
- R1: With `io_dev` equal to 1, control byte 0x08 makes later reads return the common bank (`mem_sel` = 0) and 0x04 the second bank (`mem_sel` = 1), each word taken from `mem_rdata` at the word address on `mem_addr`.
- R2: Control byte 0x02 makes every read return 0x0000 without raising `mem_en`.
- R3: Control bytes 0x00, 0x82, 0x84, 0x88 and any other code not in R1 or R2 make every read return 0xFFFF without raising `mem_en`.
- R4: Control, byte write and read strobes with `io_dev` not equal to 1 change neither the region, the pointer, the byte phase, `get_ready` nor `get_valid`.
- R5: Byte writes alternate: the first after a select loads pointer bits 15:8, the next loads bits 7:0, the one after that loads bits 15:8 again.
- R6: A control byte puts the byte phase back to the high half, whatever the earlier writes.
- R7: A read accepted at a clock edge holds `get_ready` low for exactly READ_LAT cycles; `get_valid` is high with the word for one cycle after the READ_LAT-th following edge, when `get_ready` returns high.
- R8: A read strobe while `get_ready` is low is not accepted and yields no word.
- R9: Every completed read, fill regions included, advances the pointer by one, wrapping from 0xFFFF to 0x0000.
- R10: A byte write landing in the cycle a read completes is applied on top of the incremented pointer.
- R11: The region and address of a read are fixed when it is accepted; a control byte during the wait only affects later reads.
- R12: After reset `get_ready` is 1, `get_valid` is 0, `get_data` is 0x0000, the pointer is 0x0000, the phase is high, and the region reads as all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_dev | input | 8 | Device number of the current strobe |
| io_ctrl | input | 1 | Control strobe; `io_byte` is the region code |
| io_put | input | 1 | Byte write strobe; `io_byte` is a pointer byte |
| io_get | input | 1 | Word read request, taken when `get_ready` is high |
| io_byte | input | 8 | Byte carried by control and write strobes |
| get_ready | output | 1 | High when a read request can be accepted |
| get_valid | output | 1 | One-cycle pulse marking a fresh `get_data` |
| get_data | output | 16 | Last word returned |
| mem_en | output | 1 | Storage fetch in progress (populated regions only) |
| mem_sel | output | 1 | Storage bank: 0 common, 1 second language |
| mem_addr | output | 16 | Word address being fetched |
| mem_rdata | input | 16 | Word from storage at `mem_sel`/`mem_addr` |

## Verification
The pointer has two writers that can act in one cycle: the step at read completion and a host byte write. The bench times a high-byte write to land on the very edge where a read finishes, then checks that the returned word still comes from the old address and that the next read comes from the incremented address with its high byte replaced. A second overlap, a region change during the wait, is provoked by issuing a control byte one cycle after a read is accepted and judged by the data of that read and of the one after it.

// File: rtl/ros_pkg.sv
package ros_pkg;

    // Where a word comes from; the two fill sources never touch storage.
    typedef enum logic [1:0] {
        SRC_BASIC = 2'd0,
        SRC_APL   = 2'd1,
        SRC_ZERO  = 2'd2,
        SRC_ONES  = 2'd3
    } ros_src_e;

endpackage

// File: rtl/ros_sel_decode.sv
module ros_sel_decode
    import ros_pkg::*;
#(
    parameter int          BYTE_W     = 8,
    parameter logic [7:0]  CODE_BASIC = 8'h08,
    parameter logic [7:0]  CODE_APL   = 8'h04,
    parameter logic [7:0]  CODE_ZERO  = 8'h02
) (
    input  logic [BYTE_W-1:0] code_i,
    output ros_src_e          src_o
);

    always_comb begin
        if (code_i == BYTE_W'(CODE_BASIC)) begin
            src_o = SRC_BASIC;
        end else if (code_i == BYTE_W'(CODE_APL)) begin
            src_o = SRC_APL;
        end else if (code_i == BYTE_W'(CODE_ZERO)) begin
            src_o = SRC_ZERO;
        end else begin
            src_o = SRC_ONES;   // unpopulated slots float high
        end
    end

endmodule

// File: rtl/ros_addr_seq.sv
module ros_addr_seq #(
    parameter int BYTE_W = 8,
    localparam int AW    = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              step_i,
    output logic [AW-1:0]     ptr_o
);

    typedef struct packed {
        logic [AW-1:0] ptr;
        logic          lo_next;   // 0: next write fills the high half
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step_i) begin
            st_d.ptr = st_q.ptr + 1'b1;
        end
        if (sel_i) begin
            st_d.lo_next = 1'b0;
        end else if (wr_i) begin
            if (!st_q.lo_next) begin
                st_d.ptr[AW-1:BYTE_W] = byte_i;
            end else begin
                st_d.ptr[BYTE_W-1:0] = byte_i;
            end
            st_d.lo_next = !st_q.lo_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr_o = st_q.ptr;

    a_r9_step_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !wr_i) |=> (st_q.ptr == AW'($past(st_q.ptr) + 1'b1)));

    a_r6_select_high_phase: assert property (@(posedge clk) disable iff (!rst_n)
        sel_i |=> !st_q.lo_next);

    a_r5_phase_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !sel_i) |=> (st_q.lo_next != $past(st_q.lo_next)));

    a_r10_write_over_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && wr_i && !sel_i && !st_q.lo_next) |=>
        (st_q.ptr == {$past(byte_i), $past(st_q.ptr[BYTE_W-1:0]) + 1'b1}));

endmodule

// File: rtl/ros_fetch_timer.sv
module ros_fetch_timer #(
    parameter int  READ_LAT = 4,
    localparam int CW       = (READ_LAT > 1) ? $clog2(READ_LAT) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (start_i) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CW'(READ_LAT - 1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.busy;
    assign done_o = st_q.busy && (st_q.cnt == '0);

    // Independent count of busy cycles, used only by the window check.
    logic [CW-1:0] busy_len_q;
    always_ff @(posedge clk) begin
        if (!rst_n || !st_q.busy) begin
            busy_len_q <= '0;
        end else begin
            busy_len_q <= busy_len_q + 1'b1;
        end
    end

    a_r7_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !st_q.busy) |=> busy_o);

    a_r7_window_length: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy_len_q == CW'(READ_LAT - 1)));

endmodule

// File: rtl/ros_port_ctrl.sv
module ros_port_ctrl
    import ros_pkg::*;
#(
    parameter int         BYTE_W     = 8,
    parameter logic [7:0] DEV_ID     = 8'h01,
    parameter int         READ_LAT   = 4,
    parameter logic [7:0] CODE_BASIC = 8'h08,
    parameter logic [7:0] CODE_APL   = 8'h04,
    parameter logic [7:0] CODE_ZERO  = 8'h02,
    localparam int        WORD_W     = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] io_dev,
    input  logic              io_ctrl,
    input  logic              io_put,
    input  logic              io_get,
    input  logic [BYTE_W-1:0] io_byte,
    output logic              get_ready,
    output logic              get_valid,
    output logic [WORD_W-1:0] get_data,
    output logic              mem_en,
    output logic              mem_sel,
    output logic [WORD_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rdata
);

    typedef struct packed {
        ros_src_e          src;     // region chosen by the last select
        ros_src_e          fsrc;    // region of the read in flight
        logic [WORD_W-1:0] faddr;   // address of the read in flight
        logic              valid;
        logic [WORD_W-1:0] data;
    } port_st_t;

    port_st_t          st_d, st_q;
    ros_src_e          dec_src;
    logic [WORD_W-1:0] ptr;
    logic              busy, done;
    logic              hit, sel, wr, start;

    assign hit   = (io_dev == BYTE_W'(DEV_ID));
    assign sel   = hit && io_ctrl;
    assign wr    = hit && io_put && !io_ctrl;
    assign start = hit && io_get && !busy;

    ros_sel_decode #(
        .BYTE_W     (BYTE_W),
        .CODE_BASIC (CODE_BASIC),
        .CODE_APL   (CODE_APL),
        .CODE_ZERO  (CODE_ZERO)
    ) u_decode (
        .code_i (io_byte),
        .src_o  (dec_src)
    );

    ros_addr_seq #(
        .BYTE_W (BYTE_W)
    ) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (sel),
        .wr_i   (wr),
        .byte_i (io_byte),
        .step_i (done),
        .ptr_o  (ptr)
    );

    ros_fetch_timer #(
        .READ_LAT (READ_LAT)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .busy_o  (busy),
        .done_o  (done)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (sel) begin
            st_d.src = dec_src;
        end
        if (start) begin
            st_d.fsrc  = st_q.src;
            st_d.faddr = ptr;
        end
        if (done) begin
            st_d.valid = 1'b1;
            case (st_q.fsrc)
                SRC_BASIC, SRC_APL: st_d.data = mem_rdata;
                SRC_ZERO:           st_d.data = '0;
                default:            st_d.data = '1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.src   <= SRC_ONES;
            st_q.fsrc  <= SRC_ONES;
            st_q.faddr <= '0;
            st_q.valid <= 1'b0;
            st_q.data  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign get_ready = !busy;
    assign get_valid = st_q.valid;
    assign get_data  = st_q.data;
    assign mem_en    = busy && ((st_q.fsrc == SRC_BASIC) || (st_q.fsrc == SRC_APL));
    assign mem_sel   = (st_q.fsrc == SRC_APL);
    assign mem_addr  = st_q.faddr;

    a_r7_ready_with_word: assert property (@(posedge clk) disable iff (!rst_n)
        get_valid |-> get_ready);

    a_r4_foreign_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (get_ready && !(hit && io_get)) |=> get_ready);

    a_r11_fetch_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> ($stable(mem_addr) && $stable(mem_sel)));

    a_r8_no_word_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (get_ready && !(hit && io_get)) |=> !$rose(busy));

endmodule

// File: tb/ros_port_ctrl_tb_top.sv
module ros_port_ctrl_tb_top;

    localparam int         CLK_PERIOD = 10;
    localparam int         LAT        = 4;
    localparam logic [7:0] DEV        = 8'h01;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  io_dev = DEV;
    logic        io_ctrl = 1'b0, io_put = 1'b0, io_get = 1'b0;
    logic [7:0]  io_byte = '0;
    logic        get_ready, get_valid, mem_en, mem_sel;
    logic [15:0] get_data, mem_addr, mem_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural storage contents, computed per address.
    function automatic logic [15:0] basic_word(input logic [15:0] a);
        return a ^ 16'hB5C3;
    endfunction
    function automatic logic [15:0] apl_word(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h3A17;
    endfunction

    assign mem_rdata = mem_sel ? apl_word(mem_addr) : basic_word(mem_addr);

    ros_port_ctrl #(.READ_LAT(LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .io_dev(io_dev), .io_ctrl(io_ctrl),
        .io_put(io_put), .io_get(io_get), .io_byte(io_byte),
        .get_ready(get_ready), .get_valid(get_valid), .get_data(get_data),
        .mem_en(mem_en), .mem_sel(mem_sel), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // All tasks enter and leave at a falling edge.
    task automatic put_ctrl(input logic [7:0] b, input logic [7:0] dev = DEV);
        io_dev = dev; io_ctrl = 1'b1; io_byte = b;
        @(negedge clk);
        io_ctrl = 1'b0; io_dev = DEV;
    endtask

    task automatic put_byte(input logic [7:0] b, input logic [7:0] dev = DEV);
        io_dev = dev; io_put = 1'b1; io_byte = b;
        @(negedge clk);
        io_put = 1'b0; io_dev = DEV;
    endtask

    task automatic wait_word(output logic [15:0] d, output int lat,
                             output bit mem_seen, output bit ready_ok);
        lat = 1; mem_seen = 1'b0; ready_ok = 1'b1;
        while (!get_valid && lat < 200) begin
            if (get_ready) ready_ok = 1'b0;
            if (mem_en) mem_seen = 1'b1;
            @(negedge clk);
            lat++;
        end
        d = get_data;
    endtask

    task automatic read_expect(input string tag, input logic [15:0] exp, input bit exp_mem);
        logic [15:0] d; int lat; bit ms, rok;
        io_dev = DEV; io_get = 1'b1;
        @(negedge clk);
        io_get = 1'b0;
        wait_word(d, lat, ms, rok);
        chk({tag, " data"}, d, exp);
        chk({tag, " latency R7"}, lat, LAT + 1);
        chk({tag, " ready low R7"}, rok, 1);
        chk({tag, " storage access"}, ms, exp_mem);
    endtask

    task automatic t_reset;
        chk("R12 ready after reset", get_ready, 1);
        chk("R12 valid after reset", get_valid, 0);
        chk("R12 data after reset", get_data, 0);
        read_expect("R12 reset region ones", 16'hFFFF, 1'b0);
        put_ctrl(8'h08);
        read_expect("R12 R9 pointer from zero", basic_word(16'h0001), 1'b1);
    endtask

    task automatic t_basic;
        put_ctrl(8'h08);
        put_byte(8'hC0); put_byte(8'h00);
        read_expect("R1 basic C000", basic_word(16'hC000), 1'b1);
        chk("R1 basic bank select", mem_sel, 0);
        read_expect("R1 R9 basic C001", basic_word(16'hC001), 1'b1);
        read_expect("R1 R9 basic C002", basic_word(16'hC002), 1'b1);
    endtask

    task automatic t_apl;
        put_ctrl(8'h04);
        put_byte(8'h12); put_byte(8'h34);
        read_expect("R1 apl 1234", apl_word(16'h1234), 1'b1);
        chk("R1 apl bank select", mem_sel, 1);
        read_expect("R1 apl 1235", apl_word(16'h1235), 1'b1);
    endtask

    task automatic t_fill_zero;
        put_ctrl(8'h02);
        put_byte(8'h12); put_byte(8'h00);
        read_expect("R2 zero fill a", 16'h0000, 1'b0);
        read_expect("R2 zero fill b", 16'h0000, 1'b0);
    endtask

    task automatic t_fill_ones;
        logic [7:0] codes [5] = '{8'h00, 8'h82, 8'h84, 8'h88, 8'h5A};
        for (int i = 0; i < 5; i++) begin
            put_ctrl(codes[i]);
            put_byte(8'h40); put_byte(8'h00);
            read_expect($sformatf("R3 ones fill code %02h", codes[i]), 16'hFFFF, 1'b0);
        end
    endtask

    task automatic t_foreign;
        bit saw_valid = 1'b0, saw_busy = 1'b0;
        put_ctrl(8'h08);
        put_byte(8'h03); put_byte(8'h00);
        put_ctrl(8'h04, 8'h02);
        put_byte(8'h77, 8'h02);
        io_dev = 8'h02; io_get = 1'b1;
        @(negedge clk);
        io_get = 1'b0; io_dev = DEV;
        for (int i = 0; i < LAT + 3; i++) begin
            if (get_valid) saw_valid = 1'b1;
            if (!get_ready) saw_busy = 1'b1;
            @(negedge clk);
        end
        chk("R4 foreign read no word", saw_valid, 0);
        chk("R4 foreign read no busy", saw_busy, 0);
        read_expect("R4 region pointer unchanged", basic_word(16'h0300), 1'b1);
        put_byte(8'h05);
        read_expect("R4 phase unchanged", basic_word(16'h0501), 1'b1);
    endtask

    task automatic t_phase;
        put_ctrl(8'h08);
        put_byte(8'hAB);
        put_ctrl(8'h08);
        put_byte(8'h01); put_byte(8'h02);
        read_expect("R6 select resets phase", basic_word(16'h0102), 1'b1);
        put_byte(8'h30);
        read_expect("R5 third write is high byte", basic_word(16'h3003), 1'b1);
    endtask

    task automatic t_wrap;
        put_ctrl(8'h08);
        put_byte(8'hFF); put_byte(8'hFF);
        read_expect("R9 last word", basic_word(16'hFFFF), 1'b1);
        read_expect("R9 wraps to zero", basic_word(16'h0000), 1'b1);
    endtask

    task automatic t_busy_req;
        int words = 0;
        put_ctrl(8'h08);
        put_byte(8'h20); put_byte(8'h00);
        io_get = 1'b1;
        @(negedge clk);
        @(negedge clk);   // request stays up one cycle while busy
        io_get = 1'b0;
        for (int i = 0; i < 3 * LAT; i++) begin
            if (get_valid) begin
                words++;
                chk("R8 first word data", get_data, basic_word(16'h2000));
            end
            @(negedge clk);
        end
        chk("R8 one word only", words, 1);
        read_expect("R8 pointer stepped once", basic_word(16'h2001), 1'b1);
    endtask

    task automatic t_collision;
        put_ctrl(8'h08);
        put_byte(8'h00); put_byte(8'h10);
        io_get = 1'b1;
        @(negedge clk);
        io_get = 1'b0;
        repeat (LAT - 1) @(negedge clk);
        io_put = 1'b1; io_byte = 8'h12;   // lands on the completing edge
        @(negedge clk);
        io_put = 1'b0;
        chk("R10 word on collision edge", get_valid, 1);
        chk("R10 collided word data", get_data, basic_word(16'h0010));
        read_expect("R10 write over increment", basic_word(16'h1211), 1'b1);
    endtask

    task automatic t_sel_in_flight;
        logic [15:0] d; int lat; bit ms, rok;
        put_ctrl(8'h08);
        put_byte(8'h00); put_byte(8'h40);
        io_get = 1'b1;
        @(negedge clk);
        io_get = 1'b0;
        put_ctrl(8'h04);
        wait_word(d, lat, ms, rok);
        chk("R11 in-flight read keeps region", d, basic_word(16'h0040));
        read_expect("R11 next read new region", apl_word(16'h0041), 1'b1);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_basic;
        t_apl;
        t_fill_zero;
        t_fill_ones;
        t_foreign;
        t_phase;
        t_wrap;
        t_busy_req;
        t_collision;
        t_sel_in_flight;
        finished = 1'b1;
        summary;
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            summary;
            $finish;
        end
    end

endmodule